// File: doc/BRIEF.md
# Panel register initialisation sequencer

After bring-up, this block programs a display panel over a serial link that only writes. It has a single start command. On that command it steps through a built-in list of 24 register settings. Each setting goes out as two separate chip-select framed transfers. The first transfer carries the register number and the second carries the 16-bit setting.

When the last setting has been sent, the block gives a one-cycle completion pulse. In the same cycle it raises both a panel-enable line and a backlight-enable line. A stop command lowers both lines again. The serial clock comes from dividing the system clock. Its half-period, in system clocks, is the parameter `CLK_DIV`.

Top module: `panel_init_seq`

## Requirements
- R1: Out of reset, csN is high, sclk is low, mosi is low, and busy, done, panelEn and backlightEn are all low.
- R2: An index frame is 24 bits long and is sent MSB first as three bytes. The bytes are 0x70, then 0x00, then the register number ANDed with 0x7F. Each frame has exactly 24 rising sclk edges while csN is low.
- R3: A value frame is 24 bits long and is sent MSB first as three bytes. The bytes are 0x72, then the high byte of the setting, then its low byte.
- R4: Entries go out in a fixed order, and each entry is an index frame followed by its value frame. The order, as register=value, is: 01=6300, 02=0200, 03=0177, 04=04c7, 05=ffc0, 06=e806, 0a=4008, 0b=0000, 0d=0030, 0e=2800, 0f=0000, 16=9f80, 17=0a0f, 1e=00c1, 30=0300, 31=0007, 32=0000, 33=0000, 34=0707, 35=0004, 36=0302, 37=0202, 3a=0a0d, 3b=0806.
- R5: The serial link uses mode 0. sclk idles low and each sclk phase lasts CLK_DIV system clocks. mosi changes only while sclk falls or csN falls, so it is stable while sclk is high.
- R6: Every frame has its own csN low period. Between frames, csN stays high for at least 2*CLK_DIV system clocks, and sclk is low whenever csN is high.
- R7: busy goes high one cycle after start is accepted in idle and stays high until the walk ends. A start pulse while busy is ignored, so the walk neither restarts nor adds frames.
- R8: done is high for exactly one cycle, 2*CLK_DIV+1 system clocks after csN rises at the end of the last value frame. panelEn and backlightEn rise in that same cycle, and busy falls in it.
- R9: panelEn and backlightEn are always equal, and both stay low until the walk has finished.
- R10: A stop pulse makes panelEn and backlightEn low in the next cycle. A later start runs the whole walk again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a table walk when idle |
| stop | input | 1 | Lowers both enable outputs |
| busy | output | 1 | High while a walk is in progress |
| done | output | 1 | One-cycle pulse when the walk completes |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data, MSB first |
| csN | output | 1 | Active-low chip select, one assertion per frame |
| panelEn | output | 1 | Panel enable |
| backlightEn | output | 1 | Backlight enable |

## Verification
The bench samples every output at the falling system-clock edge and keeps a cycle count.

- **Start:** after a start pulse, busy must show at the next sample.
- **Frames:** mosi is captured at each rising sclk sample. The 24 captured bits are compared against the head of the expected queue at the sample where csN is first seen high.
- **Gaps:** the high time of csN between frames is counted in samples and must reach 2*CLK_DIV.
- **Completion:** done must appear exactly 2*CLK_DIV+1 samples after csN rises at the end of the final frame, with both enables already high. It must be gone one sample later.
- **Stop:** the enables must be low at the first sample after a stop pulse.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int FRAME_BITS  = 24;
  localparam int NUM_ENTRIES = 24;
  localparam int ENTRY_W     = $clog2(NUM_ENTRIES);
  localparam logic [7:0] IDX_LEAD = 8'h70;
  localparam logic [7:0] VAL_LEAD = 8'h72;

  typedef struct packed {
    logic                  load;
    logic [FRAME_BITS-1:0] frame;
  } shift_cmd_t;

  typedef struct packed {
    logic [7:0]  addr;
    logic [15:0] val;
  } reg_pair_t;

  function automatic reg_pair_t tableEntry(input logic [ENTRY_W-1:0] idx);
    case (idx)
      5'd0:    tableEntry = '{8'h01, 16'h6300};
      5'd1:    tableEntry = '{8'h02, 16'h0200};
      5'd2:    tableEntry = '{8'h03, 16'h0177};
      5'd3:    tableEntry = '{8'h04, 16'h04c7};
      5'd4:    tableEntry = '{8'h05, 16'hffc0};
      5'd5:    tableEntry = '{8'h06, 16'he806};
      5'd6:    tableEntry = '{8'h0a, 16'h4008};
      5'd7:    tableEntry = '{8'h0b, 16'h0000};
      5'd8:    tableEntry = '{8'h0d, 16'h0030};
      5'd9:    tableEntry = '{8'h0e, 16'h2800};
      5'd10:   tableEntry = '{8'h0f, 16'h0000};
      5'd11:   tableEntry = '{8'h16, 16'h9f80};
      5'd12:   tableEntry = '{8'h17, 16'h0a0f};
      5'd13:   tableEntry = '{8'h1e, 16'h00c1};
      5'd14:   tableEntry = '{8'h30, 16'h0300};
      5'd15:   tableEntry = '{8'h31, 16'h0007};
      5'd16:   tableEntry = '{8'h32, 16'h0000};
      5'd17:   tableEntry = '{8'h33, 16'h0000};
      5'd18:   tableEntry = '{8'h34, 16'h0707};
      5'd19:   tableEntry = '{8'h35, 16'h0004};
      5'd20:   tableEntry = '{8'h36, 16'h0302};
      5'd21:   tableEntry = '{8'h37, 16'h0202};
      5'd22:   tableEntry = '{8'h3a, 16'h0a0d};
      5'd23:   tableEntry = '{8'h3b, 16'h0806};
      default: tableEntry = '{8'h00, 16'h0000};
    endcase
  endfunction

  function automatic logic [FRAME_BITS-1:0] indexFrame(input reg_pair_t p);
    indexFrame = {IDX_LEAD, 8'h00, 1'b0, p.addr[6:0]};
  endfunction

  function automatic logic [FRAME_BITS-1:0] valueFrame(input reg_pair_t p);
    valueFrame = {VAL_LEAD, p.val};
  endfunction
endpackage

// File: rtl/pis_shift.sv
module pis_shift
  import pis_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  shift_cmd_t cmd,
  output logic       frameDone,
  output logic       sclk,
  output logic       mosi,
  output logic       csN
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_t;

  sh_state_t             shState;
  logic [DIV_W-1:0]      divCnt;
  logic [BIT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] shiftReg;
  logic                  gapHalf;
  logic                  tick;

  assign tick = (divCnt == DIV_W'(CLK_DIV - 1));
  assign mosi = shiftReg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shState   <= SH_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      shiftReg  <= '0;
      gapHalf   <= 1'b0;
      frameDone <= 1'b0;
      sclk      <= 1'b0;
      csN       <= 1'b1;
    end else begin
      frameDone <= 1'b0;
      case (shState)
        SH_IDLE: begin
          if (cmd.load) begin
            shiftReg <= cmd.frame;
            csN      <= 1'b0;
            bitCnt   <= '0;
            divCnt   <= '0;
            shState  <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            if (!sclk) begin
              sclk   <= 1'b1;
              bitCnt <= bitCnt + 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitCnt == BIT_W'(FRAME_BITS)) begin
                csN     <= 1'b1;
                gapHalf <= 1'b0;
                shState <= SH_GAP;
              end else begin
                shiftReg <= shiftReg << 1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        SH_GAP: begin
          if (tick) begin
            divCnt  <= '0;
            gapHalf <= 1'b1;
            if (gapHalf) begin
              frameDone <= 1'b1;
              shState   <= SH_IDLE;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: shState <= SH_IDLE;
      endcase
    end
  end

  // R6
  cs_idle_clk_chk: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);
  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R2
  bit_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_W'(FRAME_BITS));
endmodule

// File: rtl/pis_ctrl.sv
module pis_ctrl
  import pis_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       stop,
  input  logic       frameDone,
  output shift_cmd_t cmd,
  output logic       busy,
  output logic       done,
  output logic       panelEn,
  output logic       backlightEn
);
  typedef enum logic [1:0] {C_IDLE, C_IDX, C_VAL} c_state_t;

  c_state_t           cState;
  logic [ENTRY_W-1:0] entry;
  logic               lastEntry;
  logic               walkEnd;

  assign lastEntry = (entry == ENTRY_W'(NUM_ENTRIES - 1));
  assign walkEnd   = frameDone && (cState == C_VAL) && lastEntry;
  assign busy      = (cState != C_IDLE);

  always_comb begin
    cmd.load  = 1'b0;
    cmd.frame = '0;
    case (cState)
      C_IDLE: begin
        cmd.load  = start;
        cmd.frame = indexFrame(tableEntry('0));
      end
      C_IDX: begin
        cmd.load  = frameDone;
        cmd.frame = valueFrame(tableEntry(entry));
      end
      C_VAL: begin
        cmd.load  = frameDone && !lastEntry;
        cmd.frame = indexFrame(tableEntry(entry + 1'b1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cState      <= C_IDLE;
      entry       <= '0;
      done        <= 1'b0;
      panelEn     <= 1'b0;
      backlightEn <= 1'b0;
    end else begin
      done <= 1'b0;
      case (cState)
        C_IDLE: if (start) begin
          entry  <= '0;
          cState <= C_IDX;
        end
        C_IDX: if (frameDone) cState <= C_VAL;
        C_VAL: if (frameDone) begin
          if (lastEntry) begin
            done   <= 1'b1;
            cState <= C_IDLE;
          end else begin
            entry  <= entry + 1'b1;
            cState <= C_IDX;
          end
        end
        default: cState <= C_IDLE;
      endcase
      if (stop) begin
        panelEn     <= 1'b0;
        backlightEn <= 1'b0;
      end else if (walkEnd) begin
        panelEn     <= 1'b1;
        backlightEn <= 1'b1;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R9
  enables_match_chk: assert property (@(posedge clk) disable iff (!rstN) panelEn == backlightEn);
  // R9
  en_rise_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(panelEn) |-> done);
  // R10
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> (!panelEn && !backlightEn));
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !frameDone) |=> $stable(entry));
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import pis_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic stop,
  output logic busy,
  output logic done,
  output logic sclk,
  output logic mosi,
  output logic csN,
  output logic panelEn,
  output logic backlightEn
);
  shift_cmd_t cmd;
  logic       frameDone;

  pis_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .frameDone(frameDone),
    .cmd(cmd), .busy(busy), .done(done), .panelEn(panelEn), .backlightEn(backlightEn)
  );

  pis_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .frameDone(frameDone),
    .sclk(sclk), .mosi(mosi), .csN(csN)
  );
endmodule

// File: tb/tb_panel_init_seq.sv
`timescale 1ns/1ps
module tb_panel_init_seq;
  localparam int CLK_DIV = 2;
  localparam int GAP_MIN = 2 * CLK_DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic busy, done, sclk, mosi, csN, panelEn, backlightEn;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  panel_init_seq #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .csN(csN), .panelEn(panelEn), .backlightEn(backlightEn)
  );

  logic [7:0]  expAddr [24] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0a, 8'h0b,
                                8'h0d, 8'h0e, 8'h0f, 8'h16, 8'h17, 8'h1e, 8'h30, 8'h31,
                                8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h3a, 8'h3b};
  logic [15:0] expVal  [24] = '{16'h6300, 16'h0200, 16'h0177, 16'h04c7, 16'hffc0, 16'he806,
                                16'h4008, 16'h0000, 16'h0030, 16'h2800, 16'h0000, 16'h9f80,
                                16'h0a0f, 16'h00c1, 16'h0300, 16'h0007, 16'h0000, 16'h0000,
                                16'h0707, 16'h0004, 16'h0302, 16'h0202, 16'h0a0d, 16'h0806};

  logic [23:0] expQ[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushExpected();
    for (int i = 0; i < 24; i++) begin
      expQ.push_back({8'h70, 8'h00, 1'b0, expAddr[i][6:0]});
      expQ.push_back({8'h72, expVal[i]});
    end
  endtask

  // monitor / scoreboard
  longint cyc = 0;
  longint lastRise = 0;
  int nBits = 0;
  int gapLen = 0;
  int framesSeen = 0;
  int doneSeen = 0;
  logic [23:0] cap = '0;
  logic prevSclk = 1'b0, prevCsN = 1'b1, prevDone = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!csN && sclk && !prevSclk) begin
        cap = {cap[22:0], mosi};
        nBits++;
      end
      if (!csN && prevCsN) begin
        // R6 gap between frames
        if (framesSeen > 0) check(gapLen >= GAP_MIN, "R6 csN gap", gapLen, GAP_MIN);
        nBits = 0;
        cap = '0;
      end
      if (csN) gapLen++; else gapLen = 0;
      if (csN && !prevCsN) begin
        lastRise = cyc;
        gapLen = 1;
        framesSeen++;
        check(nBits == 24, "R2 bits per frame", nBits, 24);
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected frame", cap, 0);
        end else begin
          logic [23:0] e;
          e = expQ.pop_front();
          check(cap == e, (e[23:16] == 8'h70) ? "R2 R4 index frame" : "R3 R4 value frame", cap, e);
        end
      end
      if (done) begin
        doneSeen++;
        check(cyc == lastRise + GAP_MIN + 1, "R8 done timing", cyc - lastRise, GAP_MIN + 1);
        check(panelEn && backlightEn, "R8 enables with done", {panelEn, backlightEn}, 2'b11);
        check(!busy, "R8 busy falls", busy, 0);
        check(expQ.size() == 0, "R4 all frames sent", expQ.size(), 0);
      end
      if (prevDone) check(!done, "R8 done one cycle", done, 0);
      if (busy) check(!panelEn && !backlightEn, "R9 enables low during walk",
                      {panelEn, backlightEn}, 0);
    end
    prevSclk = sclk;
    prevCsN = csN;
    prevDone = done;
  end

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic waitDone(input int startCount);
    for (int i = 0; i < 30000 && doneSeen == startCount; i++) @(negedge clk);
    check(doneSeen == startCount + 1, "R8 done arrived", doneSeen, startCount + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csN && !sclk && !mosi, "R1 serial pins", {csN, sclk, mosi}, 3'b100);
    check(!busy && !done && !panelEn && !backlightEn, "R1 status",
          {busy, done, panelEn, backlightEn}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN && !busy, "R1 idle after reset", {csN, busy}, 2'b10);

    // first walk, with a start pulse in the middle
    pushExpected();
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy, "R7 busy after start", busy, 1);
    check(!csN, "R5 frame begins", csN, 0);
    repeat (1500) @(negedge clk);
    check(busy, "R7 still busy mid walk", busy, 1);
    pulse(start);
    waitDone(0);
    @(negedge clk);
    check(framesSeen == 48, "R7 no extra frames", framesSeen, 48);
    repeat (10) @(negedge clk);
    check(panelEn && backlightEn, "R9 enables held high", {panelEn, backlightEn}, 2'b11);

    // R10 stop
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check(!panelEn && !backlightEn, "R10 stop lowers enables", {panelEn, backlightEn}, 0);
    repeat (5) @(negedge clk);
    check(!panelEn && csN, "R10 stays low", {panelEn, csN}, 2'b01);

    // second walk after stop
    pushExpected();
    pulse(start);
    waitDone(1);
    @(negedge clk);
    check(framesSeen == 96, "R10 second walk complete", framesSeen, 96);
    check(panelEn && backlightEn, "R10 enables after rerun", {panelEn, backlightEn}, 2'b11);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule